// File: doc/BRIEF.md
# Delayed Branch Retirement Arbiter

This block sits beside the fetch unit and decides, each cycle, whether fetch must be redirected and where to. Every issuing instruction may carry up to four branch operations, one per slot. Each operation has its own predicate, its own issue-to-effect delay and its own target. A branch whose predicate is false, or whose slot holds no branch, is discarded at issue. A surviving branch stays pending until its delay runs out. A delay of zero redirects fetch in the cycle right after issue, and each extra unit of delay adds one cycle.

Because delays differ, branches from several instructions can be in flight together, and some of them can mature in the same cycle. Exactly one of them then redirects fetch. The shortest original delay wins, and the highest slot number breaks ties. Every other branch maturing in that cycle is dropped for good. A target is formed in one of two ways. The relative form adds a signed offset to the entry address of the block that holds the branch. The pointer form takes a full address from an operand and ignores the offset.

An unconditional branch is issued with its predicate tied high. Prediction and recovery from misprediction are handled elsewhere.

Top module: `branch_retire_arb`

## Requirements
- R1: After reset is asserted, redirect_o is low and target_o is zero, and every branch that was pending before the reset is forgotten.
- R2: A branch with valid=1, predicate=1 and delay d, presented in the cycle before clock edge e, drives redirect_o high in the cycle that follows edge e+d, and only in that cycle. Delay is the unsigned field br_dly_i[s*DLY_W +: DLY_W].
- R3: A slot with br_valid_i[s]=0, or with br_pred_i[s]=0, never causes a redirect.
- R4: When two or more slots of one instruction are satisfied and have equal delay, the target of the highest-numbered slot is output.
- R5: When branches from different instructions mature in the same cycle, the one with the shortest original delay wins. That is the one issued most recently.
- R6: A branch that loses arbitration is dropped. It causes no redirect in any later cycle.
- R7: With br_ptr_i[s]=0 (relative form), the target is entry_addr_i plus br_off_i[s*OFF_W +: OFF_W], the offset sign-extended to ADDR_W bits and the sum taken modulo 2^ADDR_W.
- R8: With br_ptr_i[s]=1 (pointer form), the target is br_ptr_addr_i[s*ADDR_W +: ADDR_W], and the offset field has no effect.
- R9: Branches of one instruction with different delays, or of different instructions with different maturity cycles, each redirect in their own cycle.
- R10: While redirect_o is low, target_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| entry_addr_i | input | ADDR_W | Entry address of the block holding the issuing instruction |
| br_valid_i | input | SLOTS | Slot carries a branch operation |
| br_pred_i | input | SLOTS | Predicate value per slot (tied high for unconditional) |
| br_ptr_i | input | SLOTS | 1: pointer-form target, 0: relative form |
| br_dly_i | input | SLOTS*DLY_W | Issue-to-effect delay per slot |
| br_off_i | input | SLOTS*OFF_W | Signed offset per slot |
| br_ptr_addr_i | input | SLOTS*ADDR_W | Code pointer operand per slot |
| redirect_o | output | 1 | Fetch redirect this cycle |
| target_o | output | ADDR_W | Redirect address, zero when idle |

## Verification
The bench builds the block with its defaults: four slots, a 3-bit delay, 64-bit addresses and 32-bit offsets. With these values every delay from 0 to 7 can be reached, and all four slots can compete at the same level. Negative offsets can wrap around the bottom of a 64-bit address. Cross-instruction collisions are also in reach, where up to eight instructions mature in the same cycle. Random streams with every slot active set off many same-cycle collisions at different levels, and a reset is applied while branches are still pending.

// File: rtl/brr_pkg.sv
package brr_pkg;
  typedef enum logic {
    TGT_RELATIVE = 1'b0,
    TGT_POINTER  = 1'b1
  } tgt_form_e;
endpackage

// File: rtl/brr_target_calc.sv
module brr_target_calc
  import brr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 32
) (
  input  tgt_form_e          form_i,
  input  logic [ADDR_W-1:0]  entry_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [ADDR_W-1:0]  ptr_i,
  output logic [ADDR_W-1:0]  tgt_o
);
  logic [ADDR_W-1:0] off_ext;

  assign off_ext = ADDR_W'($signed(off_i));

  always_comb begin
    unique case (form_i)
      TGT_POINTER:  tgt_o = ptr_i;
      default:      tgt_o = entry_i + off_ext;
    endcase
  end
endmodule

// File: rtl/brr_level_pick.sv
// Picks the highest satisfied slot whose delay equals LEVEL.
module brr_level_pick #(
  parameter int SLOTS  = 4,
  parameter int DLY_W  = 3,
  parameter int ADDR_W = 64,
  parameter int LEVEL  = 0
) (
  input  logic [SLOTS-1:0]        sat_i,
  input  logic [SLOTS*DLY_W-1:0]  dly_i,
  input  logic [SLOTS*ADDR_W-1:0] tgt_i,
  output logic                    hit_o,
  output logic [ADDR_W-1:0]       tgt_o
);
  always_comb begin
    hit_o = 1'b0;
    tgt_o = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (sat_i[s] && (dly_i[s*DLY_W +: DLY_W] == DLY_W'(LEVEL))) begin
        hit_o = 1'b1;
        tgt_o = tgt_i[s*ADDR_W +: ADDR_W];
      end
    end
  end
endmodule

// File: rtl/brr_delay_line.sv
// One entry per remaining delay; a fresh insert always beats the shifted entry.
module brr_delay_line #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [DEPTH-1:0]        ins_hit_i,
  input  logic [DEPTH*ADDR_W-1:0] ins_tgt_i,
  output logic                    head_vld_o,
  output logic [ADDR_W-1:0]       head_addr_o
);
  logic [DEPTH-1:0]             vld_q, vld_d, sh_vld;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q, addr_d, sh_addr;

  for (genvar k = 0; k < DEPTH; k++) begin : g_lvl
    if (k == DEPTH - 1) begin : g_top
      assign sh_vld[k]  = 1'b0;
      assign sh_addr[k] = '0;
    end else begin : g_mid
      assign sh_vld[k]  = vld_q[k+1];
      assign sh_addr[k] = addr_q[k+1];
    end
    assign vld_d[k]  = ins_hit_i[k] | sh_vld[k];
    assign addr_d[k] = ins_hit_i[k] ? ins_tgt_i[k*ADDR_W +: ADDR_W] : sh_addr[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      addr_q <= '0;
    end else begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
    end
  end

  assign head_vld_o  = vld_q[0];
  assign head_addr_o = addr_q[0];
endmodule

// File: rtl/branch_retire_arb.sv
module branch_retire_arb
  import brr_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int DLY_W  = 3,
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       entry_addr_i,
  input  logic [SLOTS-1:0]        br_valid_i,
  input  logic [SLOTS-1:0]        br_pred_i,
  input  logic [SLOTS-1:0]        br_ptr_i,
  input  logic [SLOTS*DLY_W-1:0]  br_dly_i,
  input  logic [SLOTS*OFF_W-1:0]  br_off_i,
  input  logic [SLOTS*ADDR_W-1:0] br_ptr_addr_i,
  output logic                    redirect_o,
  output logic [ADDR_W-1:0]       target_o
);
  localparam int DEPTH = 1 << DLY_W;

  logic [SLOTS-1:0]        sat;
  logic [SLOTS*ADDR_W-1:0] slot_tgt;
  logic [DEPTH-1:0]        lvl_hit;
  logic [DEPTH*ADDR_W-1:0] lvl_tgt;
  logic                    head_vld;
  logic [ADDR_W-1:0]       head_addr;

  assign sat = br_valid_i & br_pred_i;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    brr_target_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_tgt (
      .form_i (tgt_form_e'(br_ptr_i[s])),
      .entry_i(entry_addr_i),
      .off_i  (br_off_i[s*OFF_W +: OFF_W]),
      .ptr_i  (br_ptr_addr_i[s*ADDR_W +: ADDR_W]),
      .tgt_o  (slot_tgt[s*ADDR_W +: ADDR_W])
    );
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_level
    brr_level_pick #(
      .SLOTS(SLOTS), .DLY_W(DLY_W), .ADDR_W(ADDR_W), .LEVEL(k)
    ) i_pick (
      .sat_i(sat),
      .dly_i(br_dly_i),
      .tgt_i(slot_tgt),
      .hit_o(lvl_hit[k]),
      .tgt_o(lvl_tgt[k*ADDR_W +: ADDR_W])
    );
  end

  brr_delay_line #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ins_hit_i  (lvl_hit),
    .ins_tgt_i  (lvl_tgt),
    .head_vld_o (head_vld),
    .head_addr_o(head_addr)
  );

  assign redirect_o = head_vld;
  assign target_o   = head_vld ? head_addr : '0;
endmodule

// File: rtl/brr_checker.sv
module brr_checker #(
  parameter int SLOTS  = 4,
  parameter int DLY_W  = 3,
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [ADDR_W-1:0]       entry_addr_i,
  input logic [SLOTS-1:0]        br_valid_i,
  input logic [SLOTS-1:0]        br_pred_i,
  input logic [SLOTS-1:0]        br_ptr_i,
  input logic [SLOTS*DLY_W-1:0]  br_dly_i,
  input logic [SLOTS*OFF_W-1:0]  br_off_i,
  input logic [SLOTS*ADDR_W-1:0] br_ptr_addr_i,
  input logic                    redirect_o,
  input logic [ADDR_W-1:0]       target_o
);
  localparam int DEPTH = 1 << DLY_W;
  localparam int CW    = DLY_W + 2;

  logic              any_sat, any_d0;
  logic [ADDR_W-1:0] exp_d0;
  logic [CW-1:0]     quiet_q;

  always_comb begin
    any_sat = 1'b0;
    any_d0  = 1'b0;
    exp_d0  = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (br_valid_i[s] && br_pred_i[s]) begin
        any_sat = 1'b1;
        if (br_dly_i[s*DLY_W +: DLY_W] == '0) begin
          any_d0 = 1'b1;
          exp_d0 = br_ptr_i[s] ? br_ptr_addr_i[s*ADDR_W +: ADDR_W]
                               : entry_addr_i + ADDR_W'($signed(br_off_i[s*OFF_W +: OFF_W]));
        end
      end
    end
  end

  // cycles since the last satisfied issue, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    quiet_q <= CW'(DEPTH);
    else if (any_sat)               quiet_q <= '0;
    else if (quiet_q < CW'(DEPTH))  quiet_q <= quiet_q + 1'b1;
  end

  AST_D0_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_d0 |=> redirect_o); // R2

  AST_D0_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_d0 |=> (target_o == $past(exp_d0))); // R4

  AST_NO_STALE_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (quiet_q < CW'(DEPTH))); // R3

  AST_IDLE_TARGET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_o |-> (target_o == '0)); // R10
endmodule

bind branch_retire_arb brr_checker #(
  .SLOTS(SLOTS), .DLY_W(DLY_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)
) i_brr_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .entry_addr_i (entry_addr_i),
  .br_valid_i   (br_valid_i),
  .br_pred_i    (br_pred_i),
  .br_ptr_i     (br_ptr_i),
  .br_dly_i     (br_dly_i),
  .br_off_i     (br_off_i),
  .br_ptr_addr_i(br_ptr_addr_i),
  .redirect_o   (redirect_o),
  .target_o     (target_o)
);

// File: tb/test_branch_retire_arb.sv
`timescale 1ns/1ps
module test_branch_retire_arb;
  localparam int SLOTS = 4, DLY_W = 3, ADDR_W = 64, OFF_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [ADDR_W-1:0] entry;
  logic              s_vld [SLOTS];
  logic              s_prd [SLOTS];
  logic              s_ptr [SLOTS];
  logic [DLY_W-1:0]  s_dly [SLOTS];
  logic [OFF_W-1:0]  s_off [SLOTS];
  logic [ADDR_W-1:0] s_pa  [SLOTS];

  logic [SLOTS-1:0]        br_valid, br_pred, br_ptr;
  logic [SLOTS*DLY_W-1:0]  br_dly;
  logic [SLOTS*OFF_W-1:0]  br_off;
  logic [SLOTS*ADDR_W-1:0] br_pa;
  logic                    redirect;
  logic [ADDR_W-1:0]       target;

  for (genvar s = 0; s < SLOTS; s++) begin : g_pack
    assign br_valid[s] = s_vld[s];
    assign br_pred[s]  = s_prd[s];
    assign br_ptr[s]   = s_ptr[s];
    assign br_dly[s*DLY_W +: DLY_W]   = s_dly[s];
    assign br_off[s*OFF_W +: OFF_W]   = s_off[s];
    assign br_pa[s*ADDR_W +: ADDR_W]  = s_pa[s];
  end

  branch_retire_arb #(.SLOTS(SLOTS), .DLY_W(DLY_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W))
  i_branch_retire_arb (
    .clk_i(clk), .rst_ni(rst_n), .entry_addr_i(entry),
    .br_valid_i(br_valid), .br_pred_i(br_pred), .br_ptr_i(br_ptr),
    .br_dly_i(br_dly), .br_off_i(br_off), .br_ptr_addr_i(br_pa),
    .redirect_o(redirect), .target_o(target)
  );

  typedef struct {
    int                mature;
    int                dly;
    int                slot;
    logic [ADDR_W-1:0] tgt;
  } pend_t;

  pend_t pend[$];
  int    edge_n = 0;
  int    errors = 0, checks = 0;
  string cur_req = "R1";

  task automatic clear_inputs();
    entry = '0;
    for (int s = 0; s < SLOTS; s++) begin
      s_vld[s] = 1'b0; s_prd[s] = 1'b0; s_ptr[s] = 1'b0;
      s_dly[s] = '0; s_off[s] = '0; s_pa[s] = '0;
    end
  endtask

  task automatic set_slot(int s, logic p, int d, logic ptr, logic [OFF_W-1:0] o,
                          logic [ADDR_W-1:0] pa);
    s_vld[s] = 1'b1; s_prd[s] = p; s_dly[s] = DLY_W'(d);
    s_ptr[s] = ptr; s_off[s] = o; s_pa[s] = pa;
  endtask

  task automatic compare(logic exp_r, logic [ADDR_W-1:0] exp_t);
    checks++;
    if (redirect !== exp_r || target !== exp_t) begin
      errors++;
      $display("FAIL %s edge=%0d redirect=%0b exp=%0b target=%h exp=%h",
               cur_req, edge_n, redirect, exp_r, target, exp_t);
    end
  endtask

  // model: capture current inputs, clock, then compare at negedge
  task automatic tick();
    pend_t nq[$];
    logic              exp_r;
    logic [ADDR_W-1:0] exp_t;
    int                best_d, best_s;
    for (int s = 0; s < SLOTS; s++) begin
      if (s_vld[s] && s_prd[s]) begin
        pend_t p;
        p.mature = edge_n + 1 + int'(s_dly[s]);
        p.dly    = int'(s_dly[s]);
        p.slot   = s;
        p.tgt    = s_ptr[s] ? s_pa[s] : entry + {{(ADDR_W-OFF_W){s_off[s][OFF_W-1]}}, s_off[s]};
        pend.push_back(p);
      end
    end
    @(posedge clk);
    edge_n++;
    exp_r = 1'b0; exp_t = '0; best_d = 1000; best_s = -1;
    foreach (pend[i]) begin
      if (pend[i].mature == edge_n) begin
        if (pend[i].dly < best_d || (pend[i].dly == best_d && pend[i].slot > best_s)) begin
          best_d = pend[i].dly; best_s = pend[i].slot;
          exp_r = 1'b1; exp_t = pend[i].tgt;
        end
      end else begin
        nq.push_back(pend[i]);
      end
    end
    pend = nq;
    @(negedge clk);
    compare(exp_r, exp_t);
    clear_inputs();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin : watchdog
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clear_inputs();
    repeat (3) @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    checks++;
    if (redirect !== 1'b0 || target !== '0) begin
      errors++;
      $display("FAIL R1 reset redirect=%0b exp=0 target=%h exp=0", redirect, target);
    end
    rst_n = 1'b1;
    idle(2);

    // R2: each delay, slot varied
    cur_req = "R2";
    for (int d = 0; d < 8; d++) begin
      entry = 64'h1000 * (d + 1);
      set_slot(d % SLOTS, 1'b1, d, 1'b0, 32'h40 + d, '0);
      tick();
      idle(9);
    end

    // R3: invalid or unsatisfied slots
    cur_req = "R3";
    entry = 64'h2000;
    set_slot(0, 1'b0, 0, 1'b0, 32'h10, '0);
    set_slot(1, 1'b0, 3, 1'b1, '0, 64'hdead);
    s_prd[2] = 1'b1; s_dly[2] = 3'd1; s_pa[2] = 64'hbeef; s_ptr[2] = 1'b1;
    tick();
    idle(9);

    // R4: equal delay in one instruction, highest slot wins
    cur_req = "R4";
    entry = 64'h3000;
    set_slot(0, 1'b1, 2, 1'b0, 32'h4, '0);
    set_slot(2, 1'b1, 2, 1'b0, 32'h8, '0);
    set_slot(3, 1'b1, 2, 1'b1, '0, 64'h3_0000_0000);
    tick();
    idle(9);

    // R9: one instruction, different delays retire separately
    cur_req = "R9";
    entry = 64'h4000;
    set_slot(1, 1'b1, 0, 1'b0, 32'h11, '0);
    set_slot(3, 1'b1, 2, 1'b0, 32'h33, '0);
    set_slot(0, 1'b1, 5, 1'b1, '0, 64'h4444);
    tick();
    idle(9);

    // R5/R6: older delay 3 and newer delay 1 collide; loser never reappears
    cur_req = "R5";
    entry = 64'h5000;
    set_slot(3, 1'b1, 3, 1'b0, 32'h50, '0);
    tick();
    idle(1);
    entry = 64'h6000;
    set_slot(0, 1'b1, 1, 1'b0, 32'h60, '0);
    tick();
    cur_req = "R6";
    idle(9);

    // R7: negative offset wraps below zero
    cur_req = "R7";
    entry = 64'h10;
    set_slot(0, 1'b1, 0, 1'b0, 32'hFFFF_FFE0, '0);
    tick();
    entry = 64'h8000_0000;
    set_slot(1, 1'b1, 0, 1'b0, 32'h8000_0000, '0);
    tick();
    idle(2);

    // R8: pointer form ignores offset
    cur_req = "R8";
    entry = 64'h7000;
    set_slot(2, 1'b1, 1, 1'b1, 32'h1234, 64'hCAFE_0000_0000_0010);
    tick();
    idle(3);

    // R10: idle target stays zero
    cur_req = "R10";
    idle(4);

    // R1: reset with pending branches
    cur_req = "R1";
    entry = 64'h9000;
    set_slot(0, 1'b1, 4, 1'b0, 32'h1, '0);
    set_slot(1, 1'b1, 7, 1'b0, 32'h2, '0);
    tick();
    rst_n = 1'b0;
    pend.delete();
    @(negedge clk);
    checks++;
    if (redirect !== 1'b0 || target !== '0) begin
      errors++;
      $display("FAIL R1 in reset redirect=%0b exp=0 target=%h exp=0", redirect, target);
    end
    rst_n = 1'b1;
    idle(10);

    // R9: random streams with many collisions
    cur_req = "R9";
    for (int i = 0; i < 3000; i++) begin
      entry = {$urandom(), $urandom()};
      for (int s = 0; s < SLOTS; s++) begin
        if ($urandom_range(0, 1) == 1)
          set_slot(s, logic'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)),
                   logic'($urandom_range(0, 1)), $urandom(), {$urandom(), $urandom()});
      end
      tick();
    end
    idle(10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule